// File: doc/BRIEF.md
# Depth-Expansion Token Ring Controller

This block is the per-slice control logic that lets several identical FIFO slices behave as one deeper FIFO. The slices form a ring: each slice's expansion output feeds the expansion input of the next slice. Two tokens travel around the ring. The write token marks the one slice that currently accepts writes. The read token marks the one slice that currently serves reads. A slice turns a write or read strobe into a local array enable only while it holds the matching token and its local array is not full (for writes) or not empty (for reads).

When a slice writes or reads the last physical location of its array, it gives up that token. In the following cycle it sends a one-cycle pulse on its expansion output. A kind bit travels with the pulse and says whether it hands over the write token or the read token. A strap input chooses the slice that starts with both tokens after reset. The controller also keeps the local write and read addresses. The array storage and the logic that combines the full and empty flags of all slices are outside this block.

Top module: `depth_ring_ctrl`

## Requirements
- R1: During reset both addresses go to 0 and the expansion output is idle. After reset a slice whose strap `first_n` is 0 holds both tokens. A slice whose strap is 1 holds neither token.
- R2: `wr_en` is 1 exactly when `wr_req` is 1, the write token is held and `slice_full` is 0. `rd_en` is 1 exactly when `rd_req` is 1, the read token is held and `slice_empty` is 0.
- R3: A slice without the write token ignores write strobes, and a slice without the read token ignores read strobes. No enable is raised and the address does not move.
- R4: A full slice raises no write enable and an empty slice raises no read enable, even while it holds the token.
- R5: A pulse on `xin_valid` with `xin_kind`=0 grants the write token, and with `xin_kind`=1 it grants the read token. The grant is taken at that clock edge, so the enable can first rise in the next cycle.
- R6: Each enabled write or read advances its address by one, and address DEPTH-1 wraps to 0.
- R7: An enabled access to address DEPTH-1 drops the matching token. In the next cycle it drives a one-cycle `xout_valid` pulse, with `xout_kind` 0 for a write-token handoff and 1 for a read-token handoff.
- R8: When a write and a read both complete the last location in the same cycle, the write-token pulse goes out first. The read-token pulse follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_n | input | 1 | Strap, 0 on the slice that starts with both tokens |
| wr_req | input | 1 | Write strobe shared by all slices |
| rd_req | input | 1 | Read strobe shared by all slices |
| slice_full | input | 1 | Local array is full |
| slice_empty | input | 1 | Local array is empty |
| xin_valid | input | 1 | Token pulse arriving from the previous slice |
| xin_kind | input | 1 | Kind of the arriving token: 0 write, 1 read |
| wr_en | output | 1 | Write enable to the local array |
| rd_en | output | 1 | Read enable to the local array |
| wr_addr | output | AW | Local write address |
| rd_addr | output | AW | Local read address |
| wr_tok | output | 1 | Write token held |
| rd_tok | output | 1 | Read token held |
| xout_valid | output | 1 | Token pulse to the next slice |
| xout_kind | output | 1 | Kind of the outgoing token: 0 write, 1 read |

## Verification
The bench exercises the main function with four input patterns:
- Strobes on a slice that holds no token. This separates token gating from full and empty gating.
- A token that arrives while a strobe is already pending. This shows the one-cycle grant latency.
- A full write pass and a full read pass around the array, each with only its own token. These show the wrap and the single tagged handoff pulse for each kind.
- Lock-stepped writes and reads that reach the last location in the same cycle. This tells apart the ordered pulse pair from a merged or lost pulse.

A scoreboard queue holds the expected order of the outgoing pulses. It flags any extra, missing or mis-tagged pulse.

// File: rtl/depth_ring_ctrl.sv
module depth_ring_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          slice_full,
  input  logic          slice_empty,
  input  logic          xin_valid,
  input  logic          xin_kind,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          wr_tok,
  output logic          rd_tok,
  output logic          xout_valid,
  output logic          xout_kind
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic pend_wr, pend_rd, wr_last, rd_last, get_wr, get_rd;

  assign wr_en   = wr_req & wr_tok & ~slice_full;
  assign rd_en   = rd_req & rd_tok & ~slice_empty;
  assign wr_last = wr_en && (wr_addr == LAST);
  assign rd_last = rd_en && (rd_addr == LAST);
  assign get_wr  = xin_valid & ~xin_kind;
  assign get_rd  = xin_valid & xin_kind;

  assign xout_valid = pend_wr | pend_rd;
  assign xout_kind  = ~pend_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr <= '0;
      rd_addr <= '0;
      wr_tok  <= ~first_n;
      rd_tok  <= ~first_n;
      pend_wr <= 1'b0;
      pend_rd <= 1'b0;
    end else begin
      if (wr_en) wr_addr <= wr_last ? '0 : wr_addr + AW'(1);
      if (rd_en) rd_addr <= rd_last ? '0 : rd_addr + AW'(1);

      if (get_wr)       wr_tok <= 1'b1;
      else if (wr_last) wr_tok <= 1'b0;
      if (get_rd)       rd_tok <= 1'b1;
      else if (rd_last) rd_tok <= 1'b0;

      pend_wr <= wr_last;
      pend_rd <= rd_last | (pend_rd & pend_wr);
    end
  end
endmodule

module depth_ring_chk #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slice_full,
  input logic          slice_empty,
  input logic          xin_valid,
  input logic          xin_kind,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          wr_tok,
  input logic          rd_tok,
  input logic          xout_valid,
  input logic          xout_kind
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  a_r3_wr_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_tok);
  a_r3_rd_needs_token: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> rd_tok);
  a_r4_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    slice_full |-> !wr_en);
  a_r4_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    slice_empty |-> !rd_en);
  a_r5_wr_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (xin_valid && !xin_kind) |=> wr_tok);
  a_r5_rd_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (xin_valid && xin_kind) |=> rd_tok);
  a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_addr));
  a_r7_wr_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST && !(xin_valid && !xin_kind))
      |=> (!wr_tok && xout_valid && !xout_kind));
  a_r7_rd_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == LAST && !(wr_en && wr_addr == LAST))
      |=> (xout_valid && xout_kind));
  a_r8_order: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == LAST && rd_en && rd_addr == LAST)
      |=> (xout_valid && !xout_kind) ##1 (xout_valid && xout_kind));
endmodule

bind depth_ring_ctrl depth_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .slice_full(slice_full), .slice_empty(slice_empty),
  .xin_valid(xin_valid), .xin_kind(xin_kind), .wr_en(wr_en), .rd_en(rd_en),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_tok(wr_tok), .rd_tok(rd_tok),
  .xout_valid(xout_valid), .xout_kind(xout_kind)
);

// File: tb/sim_depth_ring_ctrl.sv
module sim_depth_ring_ctrl;
  localparam int DEPTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, first_n = 1'b1;
  logic wr_req = 0, rd_req = 0, slice_full = 0, slice_empty = 1;
  logic xin_valid = 0, xin_kind = 0;
  logic wr_en, rd_en, wr_tok, rd_tok, xout_valid, xout_kind;
  logic [AW-1:0] wr_addr, rd_addr;

  int total = 0, fails = 0;
  logic exp_q[$];

  always #10 clk = ~clk;

  depth_ring_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .first_n(first_n), .wr_req(wr_req), .rd_req(rd_req),
    .slice_full(slice_full), .slice_empty(slice_empty), .xin_valid(xin_valid),
    .xin_kind(xin_kind), .wr_en(wr_en), .rd_en(rd_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .wr_tok(wr_tok), .rd_tok(rd_tok), .xout_valid(xout_valid),
    .xout_kind(xout_kind));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drv(logic w, logic r, logic f, logic e, logic xv, logic xk);
    @(negedge clk);
    wr_req = w; rd_req = r; slice_full = f; slice_empty = e;
    xin_valid = xv; xin_kind = xk;
    #2;
  endtask

  // monitor: every outgoing pulse must match the next expected kind
  always @(negedge clk) begin
    if (rst_n && xout_valid) begin
      if (exp_q.size() == 0) check("R7 unexpected pulse", 1, 0);
      else check("R7/R8 pulse kind", int'(xout_kind), int'(exp_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 20);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // reset as a non-first slice
    drv(0, 0, 0, 1, 0, 0);
    drv(0, 0, 0, 1, 0, 0);
    rst_n = 1'b1;
    drv(0, 0, 0, 1, 0, 0);
    check("R1 no wr token", int'(wr_tok), 0);
    check("R1 no rd token", int'(rd_tok), 0);
    check("R1 wr addr", int'(wr_addr), 0);
    check("R1 xout idle", int'(xout_valid), 0);

    // strobes without tokens
    drv(1, 1, 0, 0, 0, 0);
    check("R3 wr ignored", int'(wr_en), 0);
    check("R3 rd ignored", int'(rd_en), 0);
    drv(0, 0, 0, 1, 0, 0);
    check("R3 wr addr unchanged", int'(wr_addr), 0);
    check("R3 rd addr unchanged", int'(rd_addr), 0);

    // write token arrives while strobe pending
    drv(1, 0, 0, 1, 1, 0);
    check("R5 no enable in grant cycle", int'(wr_en), 0);
    drv(0, 0, 0, 1, 0, 0);
    check("R5 wr token taken", int'(wr_tok), 1);
    drv(1, 0, 1, 1, 0, 0);
    check("R4 full blocks write", int'(wr_en), 0);

    // full write pass
    for (int i = 0; i < DEPTH; i++) begin
      drv(1, 0, 0, 1, 0, 0);
      check("R2 wr enable", int'(wr_en), 1);
      check("R6 wr addr", int'(wr_addr), i);
      if (i == DEPTH - 1) exp_q.push_back(1'b0);
    end
    drv(0, 0, 0, 1, 0, 0);
    check("R7 wr token dropped", int'(wr_tok), 0);
    check("R6 wr addr wrapped", int'(wr_addr), 0);
    drv(1, 0, 0, 1, 0, 0);
    check("R3 wr ignored after handoff", int'(wr_en), 0);

    // read token arrives
    drv(0, 1, 0, 0, 1, 1);
    check("R5 no rd enable in grant cycle", int'(rd_en), 0);
    drv(0, 1, 0, 1, 0, 0);
    check("R5 rd token taken", int'(rd_tok), 1);
    check("R4 empty blocks read", int'(rd_en), 0);
    for (int i = 0; i < DEPTH; i++) begin
      drv(0, 1, 0, 0, 0, 0);
      check("R2 rd enable", int'(rd_en), 1);
      check("R6 rd addr", int'(rd_addr), i);
      if (i == DEPTH - 1) exp_q.push_back(1'b1);
    end
    drv(0, 0, 0, 1, 0, 0);
    check("R7 rd token dropped", int'(rd_tok), 0);
    check("R6 rd addr wrapped", int'(rd_addr), 0);
    drv(0, 0, 0, 1, 0, 0);

    // reset as first slice, lock-stepped passes
    first_n = 1'b0;
    rst_n = 1'b0;
    drv(0, 0, 0, 1, 0, 0);
    drv(0, 0, 0, 1, 0, 0);
    rst_n = 1'b1;
    drv(0, 0, 0, 1, 0, 0);
    check("R1 first holds wr token", int'(wr_tok), 1);
    check("R1 first holds rd token", int'(rd_tok), 1);
    for (int i = 0; i < DEPTH; i++) begin
      drv(1, 1, 0, 0, 0, 0);
      check("R8 both enabled", int'(wr_en & rd_en), 1);
      if (i == DEPTH - 1) begin
        exp_q.push_back(1'b0);
        exp_q.push_back(1'b1);
      end
    end
    drv(0, 0, 0, 1, 0, 0);
    check("R8 first pulse present", int'(xout_valid), 1);
    drv(0, 0, 0, 1, 0, 0);
    check("R8 second pulse present", int'(xout_valid), 1);
    drv(0, 0, 0, 1, 0, 0);
    check("R8 pulses end", int'(xout_valid), 0);
    check("R7 both tokens gone", int'(wr_tok | rd_tok), 0);
    check("R7 all pulses seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule